// File: doc/BRIEF.md
# Frequency Synthesizer Command Decoder and Register File

This block sits behind any serial front end of a frequency synthesizer control path. The front end hands it a complete 32-bit command word together with a one-cycle valid strobe. The word holds three fields: a function code, a decimal exponent and a 24-bit payload. The block multiplies the payload by ten raised to the exponent, one multiply-by-ten per clock. It then stores the result in the register that the function code selects. Five registers exist: lowest frequency (start), highest frequency (stop), channel spacing (step), reference frequency and channel number.

After each register update the block recomputes the operating frequency as start plus channel times step. It presents the result with a one-cycle valid pulse. All five registers are also driven out so that the loop-control logic downstream can use them. At reset every register takes a preset value, and the frequency output shows the frequency those presets give.

Top module: `synth_cmd_decoder`

## Requirements
- R1: After reset the registers hold start = 1500000000, stop = 2500000000, step = 1000000, reference = 20000000 and channel = 0. The frequency output is 1500000000, and busy and freq_valid are low.
- R2: The command word carries the function code in bits 31..28, the exponent in bits 27..24 and the payload in bits 23..0.
- R3: The value written is payload × 10^n, where n is the exponent.
- R4: An exponent greater than 9 is handled exactly as an exponent of 9.
- R5: If any multiply-by-ten step would exceed 48 bits, the value becomes all ones (2^48 − 1) and stays all ones.
- R6: Function code 0 writes channel, 1 writes start, 2 writes stop, 3 writes step and 4 writes reference.
- R7: Function codes 5 to 15 change no register, produce no freq_valid pulse and leave the frequency output unchanged.
- R8: A write changes only the register selected by its function code.
- R9: After a register update, freq_hz equals (start + channel × step) mod 2^48. freq_valid is high for exactly one cycle, and freq_hz changes only when freq_valid goes high.
- R10: A strobe that arrives while busy is high is dropped entirely.
- R11: For an accepted command with effective exponent n, busy is high for n+1 cycles. The register update appears one clock after busy falls, and freq_valid appears one clock after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle strobe marking cmd_word as a new command |
| cmd_word | input | 32 | Command: function code, exponent, payload |
| busy | output | 1 | Scaling in progress; strobes are dropped |
| start_hz | output | 48 | Start register |
| stop_hz | output | 48 | Stop register |
| step_hz | output | 48 | Step register |
| ref_hz | output | 48 | Reference register |
| chan_num | output | 48 | Channel register |
| freq_hz | output | 48 | Operating frequency, start + channel × step |
| freq_valid | output | 1 | One-cycle pulse when freq_hz has been recomputed |

## Verification
The assertions assume that cmd_valid is a single-cycle pulse and that the front end does not depend on a strobe issued during busy being kept. The checker therefore treats register changes during busy as errors without tracking the dropped command. The stimulus raises cmd_valid for one clock per command and waits for busy to fall before the next. The one exception is a deliberate strobe inside a long scaling run. Between them, the command sweeps cover every function code against every exponent value, including the clamped and saturating ones.

// File: rtl/synth_cmd_pkg.sv
package synth_cmd_pkg;
  localparam int FN_W   = 4;
  localparam int EXP_W  = 4;
  localparam int PAY_W  = 24;
  localparam int CMD_W  = FN_W + EXP_W + PAY_W;
  localparam int NUM_REGS = 5;

  typedef enum logic [FN_W-1:0] {
    FN_CHAN  = 4'd0,
    FN_START = 4'd1,
    FN_STOP  = 4'd2,
    FN_STEP  = 4'd3,
    FN_REF   = 4'd4
  } fn_code_e;

  typedef struct packed {
    logic [FN_W-1:0]  fn;
    logic [EXP_W-1:0] expo;
    logic [PAY_W-1:0] pay;
  } cmd_fields_t;
endpackage

// File: rtl/pow10_scaler.sv
module pow10_scaler #(
  parameter int DW      = 48,
  parameter int PW      = 24,
  parameter int EW      = 4,
  parameter int FW      = 4,
  parameter int EXP_MAX = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [PW-1:0] pay_i,
  input  logic [EW-1:0] exp_i,
  input  logic [FW-1:0] fn_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] val_o,
  output logic [FW-1:0] fn_o
);
  localparam int CW = $clog2(EXP_MAX + 1);
  localparam logic [EW-1:0] EXP_LIM = EW'(EXP_MAX);

  logic [DW-1:0] acc;
  logic [CW-1:0] cnt;
  logic [DW+3:0] wide;
  logic          ovf;
  logic [CW-1:0] exp_c;

  // x*10 as x*8 + x*2 in a widened word
  assign wide  = ({4'b0, acc} << 3) + ({4'b0, acc} << 1);
  assign ovf   = |wide[DW+3:DW];
  assign exp_c = (exp_i > EXP_LIM) ? CW'(EXP_LIM) : CW'(exp_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      cnt    <= '0;
      fn_o   <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        if (start_i) begin
          acc    <= DW'(pay_i);
          cnt    <= exp_c;
          fn_o   <= fn_i;
          busy_o <= 1'b1;
        end
      end else if (cnt != '0) begin
        acc <= ovf ? '1 : wide[DW-1:0];
        cnt <= cnt - CW'(1);
      end else begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
      end
    end
  end

  assign val_o = acc;
endmodule

// File: rtl/synth_regfile.sv
module synth_regfile
  import synth_cmd_pkg::*;
#(
  parameter int DW = 48,
  parameter longint unsigned START_DEF = 64'd1500000000,
  parameter longint unsigned STOP_DEF  = 64'd2500000000,
  parameter longint unsigned STEP_DEF  = 64'd1000000,
  parameter longint unsigned REF_DEF   = 64'd20000000,
  parameter longint unsigned CHAN_DEF  = 64'd0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_i,
  input  logic [FN_W-1:0] fn_i,
  input  logic [DW-1:0]   val_i,
  output logic [DW-1:0]   start_o,
  output logic [DW-1:0]   stop_o,
  output logic [DW-1:0]   step_o,
  output logic [DW-1:0]   ref_o,
  output logic [DW-1:0]   chan_o,
  output logic            upd_o
);
  logic [DW-1:0] regs [NUM_REGS];

  function automatic logic [DW-1:0] preset(input int idx);
    case (idx)
      int'(FN_CHAN):  return DW'(CHAN_DEF);
      int'(FN_START): return DW'(START_DEF);
      int'(FN_STOP):  return DW'(STOP_DEF);
      int'(FN_STEP):  return DW'(STEP_DEF);
      default:        return DW'(REF_DEF);
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= preset(i);
      upd_o <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++)
        if (wr_i && fn_i == FN_W'(i)) regs[i] <= val_i;
      upd_o <= wr_i && (fn_i < FN_W'(NUM_REGS));
    end
  end

  assign chan_o  = regs[FN_CHAN];
  assign start_o = regs[FN_START];
  assign stop_o  = regs[FN_STOP];
  assign step_o  = regs[FN_STEP];
  assign ref_o   = regs[FN_REF];
endmodule

// File: rtl/freq_calc.sv
module freq_calc #(
  parameter int DW = 48,
  parameter logic [DW-1:0] FREQ_RST = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd_i,
  input  logic [DW-1:0] start_i,
  input  logic [DW-1:0] step_i,
  input  logic [DW-1:0] chan_i,
  output logic [DW-1:0] freq_o,
  output logic          valid_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      freq_o  <= FREQ_RST;
      valid_o <= 1'b0;
    end else begin
      valid_o <= upd_i;
      if (upd_i) freq_o <= start_i + chan_i * step_i;
    end
  end
endmodule

// File: rtl/synth_cmd_decoder.sv
module synth_cmd_decoder
  import synth_cmd_pkg::*;
#(
  parameter int DW      = 48,
  parameter int EXP_MAX = 9,
  parameter longint unsigned START_DEF = 64'd1500000000,
  parameter longint unsigned STOP_DEF  = 64'd2500000000,
  parameter longint unsigned STEP_DEF  = 64'd1000000,
  parameter longint unsigned REF_DEF   = 64'd20000000,
  parameter longint unsigned CHAN_DEF  = 64'd0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_word,
  output logic             busy,
  output logic [DW-1:0]    start_hz,
  output logic [DW-1:0]    stop_hz,
  output logic [DW-1:0]    step_hz,
  output logic [DW-1:0]    ref_hz,
  output logic [DW-1:0]    chan_num,
  output logic [DW-1:0]    freq_hz,
  output logic             freq_valid
);
  localparam logic [DW-1:0] FREQ_RST = DW'(START_DEF + CHAN_DEF * STEP_DEF);

  cmd_fields_t     cmd;
  logic            sc_done;
  logic [DW-1:0]   sc_val;
  logic [FN_W-1:0] sc_fn;
  logic            rf_upd;

  assign cmd = cmd_fields_t'(cmd_word);

  pow10_scaler #(
    .DW(DW), .PW(PAY_W), .EW(EXP_W), .FW(FN_W), .EXP_MAX(EXP_MAX)
  ) u_scale (
    .clk(clk), .rst(rst), .start_i(cmd_valid),
    .pay_i(cmd.pay), .exp_i(cmd.expo), .fn_i(cmd.fn),
    .busy_o(busy), .done_o(sc_done), .val_o(sc_val), .fn_o(sc_fn)
  );

  synth_regfile #(
    .DW(DW), .START_DEF(START_DEF), .STOP_DEF(STOP_DEF),
    .STEP_DEF(STEP_DEF), .REF_DEF(REF_DEF), .CHAN_DEF(CHAN_DEF)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_i(sc_done), .fn_i(sc_fn), .val_i(sc_val),
    .start_o(start_hz), .stop_o(stop_hz), .step_o(step_hz),
    .ref_o(ref_hz), .chan_o(chan_num), .upd_o(rf_upd)
  );

  freq_calc #(.DW(DW), .FREQ_RST(FREQ_RST)) u_freq (
    .clk(clk), .rst(rst), .upd_i(rf_upd),
    .start_i(start_hz), .step_i(step_hz), .chan_i(chan_num),
    .freq_o(freq_hz), .valid_o(freq_valid)
  );
endmodule

// File: rtl/synth_cmd_decoder_chk.sv
module synth_cmd_decoder_chk #(
  parameter int DW      = 48,
  parameter int EXP_MAX = 9
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic          busy,
  input logic [DW-1:0] start_hz,
  input logic [DW-1:0] stop_hz,
  input logic [DW-1:0] step_hz,
  input logic [DW-1:0] ref_hz,
  input logic [DW-1:0] chan_num,
  input logic [DW-1:0] freq_hz,
  input logic          freq_valid
);
  logic [7:0] busy_run;

  always_ff @(posedge clk) begin
    if (rst) busy_run <= '0;
    else     busy_run <= busy ? busy_run + 8'd1 : 8'd0;
  end

  // R11
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy) |=> busy);

  // R4
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    busy_run <= 8'(EXP_MAX + 1));

  // R10
  regs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> ($stable(start_hz) && $stable(stop_hz) && $stable(step_hz)
              && $stable(ref_hz) && $stable(chan_num)));

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    freq_valid |=> !freq_valid);

  // R9
  freq_value_chk: assert property (@(posedge clk) disable iff (rst)
    freq_valid |-> (freq_hz == DW'(start_hz + chan_num * step_hz)));

  // R9
  freq_change_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(freq_hz) |-> freq_valid);
endmodule

bind synth_cmd_decoder synth_cmd_decoder_chk #(.DW(DW), .EXP_MAX(EXP_MAX)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .busy(busy),
  .start_hz(start_hz), .stop_hz(stop_hz), .step_hz(step_hz),
  .ref_hz(ref_hz), .chan_num(chan_num), .freq_hz(freq_hz),
  .freq_valid(freq_valid)
);

// File: tb/synth_cmd_decoder_tb.sv
module synth_cmd_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 150000;
  localparam logic [47:0] ALL1 = 48'hFFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [31:0] cmd_word = '0;
  logic        busy;
  logic [47:0] start_hz, stop_hz, step_hz, ref_hz, chan_num, freq_hz;
  logic        freq_valid;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic [47:0] m [5];   // 0 chan, 1 start, 2 stop, 3 step, 4 ref

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_cmd_decoder u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .busy(busy), .start_hz(start_hz), .stop_hz(stop_hz), .step_hz(step_hz),
    .ref_hz(ref_hz), .chan_num(chan_num), .freq_hz(freq_hz),
    .freq_valid(freq_valid)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WDOG_CYCLES) begin
      failures = failures + 1;
      $display("FAIL watchdog act=%0d exp<=%0d", cycles, WDOG_CYCLES);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [47:0] dut_reg(input int i);
    case (i)
      0: return chan_num;
      1: return start_hz;
      2: return stop_hz;
      3: return step_hz;
      default: return ref_hz;
    endcase
  endfunction

  function automatic logic [47:0] p10(input logic [23:0] p, input int n);
    logic [47:0] x = {24'b0, p};
    for (int i = 0; i < n; i++) begin
      if (x > ALL1 / 10) x = ALL1;
      else x = x * 48'd10;
    end
    return x;
  endfunction

  function automatic logic [47:0] mfreq();
    logic [47:0] r;
    r = m[1] + m[0] * m[3];
    return r;
  endfunction

  task automatic check_regs(input string req);
    for (int i = 0; i < 5; i++) chk(req, $sformatf("reg%0d", i), dut_reg(i), m[i]);
  endtask

  // send one command; optional intruding strobe during busy
  task automatic send(input int fn, input int ex, input logic [23:0] pay,
                      input bit intrude);
    int n, cnt;
    logic [47:0] v;
    string tag;
    n = (ex > 9) ? 9 : ex;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = {4'(fn), 4'(ex), pay};
    @(negedge clk);
    cmd_valid = 1'b0;
    cnt = 0;
    while (busy) begin
      if (intrude && cnt == 1) begin
        cmd_valid = 1'b1;
        cmd_word  = {4'd2, 4'd0, 24'd777};   // stop write, must be dropped (R10)
      end else begin
        cmd_valid = 1'b0;
      end
      cnt++;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    chk("R11", "busy cycles", 48'(cnt), 48'(n + 1));
    chk("R11", "early freq_valid", 48'(freq_valid), 48'd0);
    v = p10(pay, n);
    if (ex > 9) tag = "R4";
    else if (v == ALL1) tag = "R5";
    else tag = "R3";
    if (fn < 5) m[fn] = v;
    @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      if (fn >= 5)
        chk("R7", $sformatf("reserved fn%0d reg%0d", fn, i), dut_reg(i), m[i]);
      else if (i == fn)
        chk(tag, $sformatf("R6 fn%0d ex%0d pay%0d", fn, ex, pay), dut_reg(i), m[i]);
      else
        chk(intrude ? "R10" : "R8", $sformatf("other reg%0d", i), dut_reg(i), m[i]);
    end
    chk("R11", "freq_valid before calc", 48'(freq_valid), 48'd0);
    @(negedge clk);
    chk(fn < 5 ? "R9" : "R7", "freq_valid", 48'(freq_valid), (fn < 5) ? 48'd1 : 48'd0);
    chk("R9", "freq_hz", freq_hz, mfreq());
    @(negedge clk);
    chk("R9", "freq_valid one cycle", 48'(freq_valid), 48'd0);
  endtask

  initial begin
    m[0] = 48'd0; m[1] = 48'd1500000000; m[2] = 48'd2500000000;
    m[3] = 48'd1000000; m[4] = 48'd20000000;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset presets
    check_regs("R1");
    chk("R1", "reset freq", freq_hz, 48'd1500000000);
    chk("R1", "reset busy", 48'(busy), 48'd0);
    chk("R1", "reset freq_valid", 48'(freq_valid), 48'd0);

    // R2 field positions: realistic channel setup
    send(3, 5, 24'd1, 1'b0);      // step 100 kHz
    send(0, 0, 24'd42, 1'b0);     // channel 42
    chk("R2", "freq channel 42", freq_hz, 48'd1504200000);

    // R10 strobe during busy dropped
    send(3, 9, 24'd5, 1'b1);

    // sweep every function code against every exponent
    for (int f = 0; f < 16; f++)
      for (int e = 0; e < 16; e++)
        for (int k = 0; k < 5; k++) begin
          logic [23:0] pay;
          case (k)
            0: pay = 24'd0;
            1: pay = 24'd1;
            2: pay = 24'd7;
            3: pay = 24'd123456;
            default: pay = 24'hFFFFFF;
          endcase
          send(f, e, pay, 1'b0);
        end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule